// File: doc/BRIEF.md
# Serial Flash Command Front End with Status and Write-Enable Gating

This block sits behind a mode-0 serial peripheral port and decodes the commands of a serial flash. It owns the status byte: a write-enable latch, a busy flag, a lock bit that freezes the protection setting, and a protect-everything flag. It serves status reads that repeat for as long as the select line stays low. It handles enable, disable and status-write commands itself. For program, erase, protect and unprotect it only gates the command: it checks the latch and then pulses a start strobe to a downstream engine. The engine later reports completion or abort.

All serial inputs are sampled by the system clock, which must run at least four times as fast as SCK and be synchronous to the serial signals. Every command is judged at the rising edge of the select line from the number of bits received. A command cut short inside its opcode, or an unknown opcode, leaves the latch untouched. A guarded command cut short after its opcode clears the latch. A programmable busy stub keeps the busy flag high for `busy_len` clocks after each accepted write-type command.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `so_oe` is low and no start pulse appears.
- R2: Opcode 06h followed by the select rising after exactly 8 bits sets the write-enable latch. Opcode 04h with exactly 8 bits clears it. Any other bit count for these opcodes leaves the latch unchanged.
- R3: The status byte is {lock, 0, 0, 0, 0, protect-all, write-enable latch, busy}, with bit 7 first. After opcode 05h, status bytes are driven on `so` MSB first, changing on SCK falling edges. A fresh snapshot is taken at the start of every byte while select stays low. `so_oe` is low during the opcode and while select is high.
- R4: While the latch is 0, the guarded opcodes 02h, 20h, 60h, 36h, 39h and 01h have no effect and raise no start pulse.
- R5: With the latch set, opcode 01h plus at least 16 bits performs a status write. Data bit 7 becomes the lock bit. Data bits 5:2 equal to 1111b set protect-all, equal to 0000b clear it, and any other value leaves it as it is. Bits 6, 1 and 0 are ignored. If the lock bit was already 1, protect-all does not change. The latch clears.
- R6: With the latch set, opcode 01h followed by the select rising after 8 to 15 bits is an abort: the latch clears and lock and protect-all keep their values.
- R7: With the latch set, an engine command reaches the engine once enough bits have arrived: 40 bits for 02h, 32 bits for 20h, 36h and 39h, and 8 bits for 60h. The block then raises `eng_start` for one clock, with the opcode on `eng_op` and bits 8 to 31 of the frame (MSB first) on `eng_addr`.
- R8: With the latch set, an engine command whose full opcode arrived but which falls short of its bit count clears the latch and raises no start pulse.
- R9: A select rise before 8 bits, or an unrecognised opcode, leaves the latch unchanged.
- R10: Busy is 1 while an engine command is outstanding or the busy stub is counting. `eng_done` or `eng_abort` ends the outstanding command and clears the latch. The latch stays set until then.
- R11: While busy, every command except the status read is ignored, and status reads still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so`; low means high impedance |
| busy_len | input | TMRW | Busy stub length in clocks |
| eng_start | output | 1 | One-clock start strobe to the engine |
| eng_op | output | 8 | Opcode of the started command |
| eng_addr | output | 24 | Address bits of the started command |
| eng_done | input | 1 | Engine reports completion |
| eng_abort | input | 1 | Engine reports abort |

## Verification
The case of most interest is a completion from the engine arriving while a status stream is running. It is provoked by pulsing `eng_done` in a parallel thread in the middle of a four-byte status read. The first byte must report busy with the latch set, and the last byte must report both cleared, which shows that each byte takes its own snapshot. A second overlap is a write command whose select rise lands while busy. It is judged by the absence of a further start strobe and by the latch value read back afterwards.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int OPW  = 8;
    localparam int CNTW = 6;
    localparam int ADRW = 24;
    localparam logic [CNTW-1:0] CNT_MAX = '1;

    localparam logic [OPW-1:0] OP_RDSR = 8'h05;
    localparam logic [OPW-1:0] OP_WREN = 8'h06;
    localparam logic [OPW-1:0] OP_WRDI = 8'h04;
    localparam logic [OPW-1:0] OP_WRSR = 8'h01;
    localparam logic [OPW-1:0] OP_PROG = 8'h02;
    localparam logic [OPW-1:0] OP_BERS = 8'h20;
    localparam logic [OPW-1:0] OP_CERS = 8'h60;
    localparam logic [OPW-1:0] OP_PROT = 8'h36;
    localparam logic [OPW-1:0] OP_UNPR = 8'h39;

    // bits a guarded command needs before the select rise; 0 = not guarded
    function automatic logic [CNTW-1:0] need_bits(input logic [OPW-1:0] op);
        case (op)
            OP_WRSR: need_bits = 6'd16;
            OP_PROG: need_bits = 6'd40;
            OP_BERS, OP_PROT, OP_UNPR: need_bits = 6'd32;
            OP_CERS: need_bits = 6'd8;
            default: need_bits = '0;
        endcase
    endfunction

    typedef struct packed {
        logic            wel;
        logic            lock;
        logic            allp;
        logic            pend;
        logic            start;
        logic [OPW-1:0]  op;
        logic [ADRW-1:0] addr;
    } ctl_t;
endpackage

// File: rtl/sfc_edges.sv
module sfc_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    typedef struct packed { logic sck; logic cs; } edg_t;
    edg_t e_d, e_q;

    always_comb begin
        e_d.sck = sck;
        e_d.cs  = cs_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '{sck: 1'b0, cs: 1'b1};
        else        e_q <= e_d;
    end

    assign sck_rise = sck & ~e_q.sck & ~cs_n;
    assign sck_fall = ~sck & e_q.sck & ~cs_n;
    assign cs_rise  = cs_n & ~e_q.cs;
endmodule

// File: rtl/sfc_rx.sv
module sfc_rx
    import sfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            rise,
    input  logic            si,
    output logic [CNTW-1:0] bits,
    output logic [OPW-1:0]  op,
    output logic [7:0]      wbyte,
    output logic [ADRW-1:0] addr
);
    localparam int SHW = OPW + ADRW;

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic [SHW-1:0]  sh;
        logic [OPW-1:0]  op;
        logic [7:0]      wb;
    } rx_t;
    rx_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!sel) begin
            r_d.cnt = '0;
        end else if (rise) begin
            if (r_q.cnt < CNTW'(SHW)) r_d.sh = {r_q.sh[SHW-2:0], si};
            if (r_q.cnt != CNT_MAX)   r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt == CNTW'(OPW-1)) r_d.op = {r_q.sh[OPW-2:0], si};
            if (r_q.cnt == CNTW'(OPW+7)) r_d.wb = {r_q.sh[6:0], si};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bits  = r_q.cnt;
    assign op    = r_q.op;
    assign wbyte = r_q.wb;
    assign addr  = r_q.sh[ADRW-1:0];
endmodule

// File: rtl/sfc_tx.sv
module sfc_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       fall,
    input  logic       en,
    input  logic [7:0] status,
    output logic       so,
    output logic       so_oe
);
    typedef struct packed {
        logic       act;
        logic       so;
        logic [6:0] sr;
        logic [2:0] cnt;
    } tx_t;
    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!sel) begin
            t_d.act = 1'b0;
            t_d.cnt = '0;
        end else if (fall && en) begin
            t_d.act = 1'b1;
            if (t_q.cnt == '0) begin
                t_d.so  = status[7];
                t_d.sr  = status[6:0];
                t_d.cnt = 3'd7;
            end else begin
                t_d.so  = t_q.sr[6];
                t_d.sr  = {t_q.sr[5:0], 1'b0};
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign so    = t_q.so;
    assign so_oe = t_q.act;
endmodule

// File: rtl/sfc_busy_tmr.sv
module sfc_busy_tmr #(
    parameter int TMRW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TMRW-1:0] len,
    output logic            run
);
    logic [TMRW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = len;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign run = (cnt_q != '0);
endmodule

// File: rtl/sflash_cmd_ctrl.sv
module sflash_cmd_ctrl
    import sfc_pkg::*;
#(
    parameter int TMRW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            si,
    output logic            so,
    output logic            so_oe,
    input  logic [TMRW-1:0] busy_len,
    output logic            eng_start,
    output logic [OPW-1:0]  eng_op,
    output logic [ADRW-1:0] eng_addr,
    input  logic            eng_done,
    input  logic            eng_abort
);
    logic            sck_rise, sck_fall, cs_rise;
    logic [CNTW-1:0] rx_bits;
    logic [OPW-1:0]  rx_op;
    logic [7:0]      rx_byte;
    logic [ADRW-1:0] rx_addr;
    logic            tmr_run, tmr_load, busy, rd_en;
    logic [CNTW-1:0] need;
    logic [7:0]      status;
    ctl_t            s_d, s_q;

    sfc_edges u_edges (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    sfc_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sel(~cs_n), .rise(sck_rise), .si(si),
        .bits(rx_bits), .op(rx_op), .wbyte(rx_byte), .addr(rx_addr)
    );

    sfc_tx u_tx (
        .clk(clk), .rst_n(rst_n), .sel(~cs_n), .fall(sck_fall), .en(rd_en),
        .status(status), .so(so), .so_oe(so_oe)
    );

    sfc_busy_tmr #(.TMRW(TMRW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(busy_len), .run(tmr_run)
    );

    assign busy   = s_q.pend | tmr_run;
    assign rd_en  = (rx_bits >= CNTW'(OPW)) && (rx_op == OP_RDSR);
    assign need   = need_bits(rx_op);
    assign status = {s_q.lock, 4'b0000, s_q.allp, s_q.wel, busy};

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        tmr_load  = 1'b0;
        if (s_q.pend && (eng_done || eng_abort)) begin
            s_d.pend = 1'b0;
            s_d.wel  = 1'b0;
        end
        if (cs_rise && (rx_bits >= CNTW'(OPW)) && !busy) begin
            if (rx_op == OP_WREN) begin
                if (rx_bits == CNTW'(OPW)) s_d.wel = 1'b1;
            end else if (rx_op == OP_WRDI) begin
                if (rx_bits == CNTW'(OPW)) s_d.wel = 1'b0;
            end else if ((need != '0) && s_q.wel) begin
                if (rx_bits < need) begin
                    s_d.wel = 1'b0;
                end else if (rx_op == OP_WRSR) begin
                    s_d.wel  = 1'b0;
                    s_d.lock = rx_byte[7];
                    tmr_load = 1'b1;
                    if (!s_q.lock) begin
                        if (rx_byte[5:2] == 4'hF)      s_d.allp = 1'b1;
                        else if (rx_byte[5:2] == 4'h0) s_d.allp = 1'b0;
                    end
                end else begin
                    s_d.start = 1'b1;
                    s_d.pend  = 1'b1;
                    s_d.op    = rx_op;
                    s_d.addr  = (need >= CNTW'(OPW + ADRW)) ? rx_addr : '0;
                    tmr_load  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign eng_start = s_q.start;
    assign eng_op    = s_q.op;
    assign eng_addr  = s_q.addr;
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic so_oe,
    input logic eng_start,
    input logic eng_done,
    input logic eng_abort,
    input logic wel,
    input logic pend,
    input logic busy
);
    assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !so_oe);

    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (wel && $past(wel)));

    assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(busy));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && (eng_done || eng_abort)) |=> (!wel && !pend));

    assert_wel_on_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_n));
endmodule

bind sflash_cmd_ctrl sfc_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe),
    .eng_start(eng_start), .eng_done(eng_done), .eng_abort(eng_abort),
    .wel(s_q.wel), .pend(s_q.pend), .busy(busy)
);

// File: tb/sflash_cmd_ctrl_tb.sv
module sflash_cmd_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic        so, so_oe;
    logic [15:0] busy_len = 16'd5;
    logic        eng_start;
    logic [7:0]  eng_op;
    logic [23:0] eng_addr;
    logic        eng_done = 1'b0, eng_abort = 1'b0;

    int checks = 0, fails = 0;
    int starts = 0;
    logic [7:0]  last_op;
    logic [23:0] last_addr;
    logic [39:0] rxv;
    int oe_hi, oe_lo;
    logic m_wel = 0, m_lock = 0, m_allp = 0;

    always #10 clk = ~clk;

    sflash_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .busy_len(busy_len),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr),
        .eng_done(eng_done), .eng_abort(eng_abort)
    );

    always @(negedge clk) if (eng_start) begin
        starts++;
        last_op   = eng_op;
        last_addr = eng_addr;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] st(input logic b);
        return {m_lock, 4'b0000, m_allp, m_wel, b};
    endfunction

    task automatic send(input logic [39:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            si = v[i];
            @(negedge clk); @(negedge clk);
            rxv = {rxv[38:0], so};
            if (so_oe) oe_hi++; else oe_lo++;
            sck = 1'b1;
            @(negedge clk); @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // sends the top n bits of a 40-bit frame
    task automatic cmd(input logic [39:0] w, input int n);
        cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        if (n > 0) send(w >> (40 - n), n);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input int nbytes, output logic [31:0] got, output int op_oe, output int dat_lo);
        cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        oe_hi = 0; oe_lo = 0;
        send(40'h05, 8);
        op_oe = oe_hi;
        oe_hi = 0; oe_lo = 0;
        send(40'h0, 8 * nbytes);
        dat_lo = oe_lo;
        got = rxv[31:0];
        @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd1(output logic [7:0] b);
        logic [31:0] g; int a, c;
        rd(1, g, a, c);
        b = g[7:0];
    endtask

    task automatic wren();
        cmd({8'h06, 32'h0}, 8);
        m_wel = 1;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [31:0] g;
        int a, c, s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 so_oe", {31'b0, so_oe}, 32'd0);
        rd(1, g, a, c);
        check("R1 status", g[7:0], 8'h00);
        check("R1 no start", starts, 0);
        check("R3 oe low during opcode", a, 0);
        check("R3 oe high during data", c, 0);

        // R2 / R9 partial enable sweep leaves latch clear
        for (int n = 1; n <= 12; n++) begin
            if (n == 8) continue;
            cmd({8'h06, 32'h0}, n);
            rd1(b);
            check($sformatf("R2 wren n=%0d", n), b, st(0));
        end
        wren();
        rd1(b); check("R2 wren sets", b, st(0));

        // R9 disable with wrong length, unknown opcodes, cut opcodes
        for (int n = 1; n <= 12; n++) begin
            if (n == 8) continue;
            cmd({8'h04, 32'h0}, n);
        end
        rd1(b); check("R2 wrdi wrong len", b, st(0));
        cmd({8'hAA, 32'h0}, 8); cmd({8'hFF, 32'h0}, 16); cmd({8'h00, 32'h0}, 8);
        cmd({8'h02, 32'h0}, 5); cmd({8'h60, 32'h0}, 7); cmd({8'h01, 32'h0}, 3);
        rd1(b); check("R9 latch kept", b, st(0));
        cmd({8'h04, 32'h0}, 8); m_wel = 0;
        rd1(b); check("R2 wrdi clears", b, st(0));

        // R4 guarded commands without latch
        cmd({8'h60, 32'h0}, 8);
        cmd({8'h20, 24'h123456, 8'h0}, 32);
        cmd({8'h02, 24'h1, 8'h55}, 40);
        cmd({8'h36, 32'h0}, 32); cmd({8'h39, 32'h0}, 32);
        cmd({8'h01, 8'hFC, 24'h0}, 16);
        rd1(b); check("R4 ignored status", b, st(0));
        check("R4 no start", starts, 0);

        // R5 status write sweep over global field and lock
        for (int lk = 0; lk < 2; lk++)
            for (int gf = 0; gf < 16; gf++) begin
                wren();
                cmd({8'h01, lk[0], 1'b0, gf[3:0], 2'b11, 24'h0}, 16);
                if (!m_lock) begin
                    if (gf == 15) m_allp = 1;
                    else if (gf == 0) m_allp = 0;
                end
                m_lock = lk[0]; m_wel = 0;
                rd1(b);
                check($sformatf("R5 wrsr lk=%0d g=%0d", lk, gf), b, st(0));
            end
        wren(); cmd({8'h01, 8'h00, 24'h0}, 16); m_lock = 0; m_wel = 0;
        wren(); cmd({8'h01, 8'h3C, 24'h0}, 20); m_allp = 1; m_wel = 0;
        rd1(b); check("R5 unlock then set", b, st(0));

        // R6 short status write aborts
        for (int n = 8; n <= 15; n++) begin
            wren();
            cmd({8'h01, 8'h80, 24'h0}, n);
            m_wel = 0;
            rd1(b);
            check($sformatf("R6 abort n=%0d", n), b, st(0));
        end

        // R7 / R10 engine commands
        wren(); s0 = starts;
        cmd({8'h60, 32'h0}, 8);
        check("R7 ce start", starts, s0 + 1);
        check("R7 ce op", last_op, 8'h60);
        rd1(b); check("R10 busy latch held", b, st(1));
        eng_done = 1; @(negedge clk); eng_done = 0; m_wel = 0;
        rd1(b); check("R10 done clears", b, st(0));

        wren(); cmd({8'h20, 24'h123456, 8'h0}, 32);
        check("R7 be op", last_op, 8'h20);
        check("R7 be addr", last_addr, 24'h123456);
        eng_abort = 1; @(negedge clk); eng_abort = 0; m_wel = 0;
        rd1(b); check("R10 abort clears", b, st(0));

        wren(); cmd({8'h02, 24'hABCDEF, 8'h5A}, 40);
        check("R7 prog op", last_op, 8'h02);
        check("R7 prog addr", last_addr, 24'hABCDEF);
        eng_done = 1; @(negedge clk); eng_done = 0; m_wel = 0;
        wren(); cmd({8'h36, 24'h0F0F0F, 8'h0}, 32);
        check("R7 protect addr", last_addr, 24'h0F0F0F);
        eng_done = 1; @(negedge clk); eng_done = 0; m_wel = 0;
        wren(); cmd({8'h39, 24'h707070, 8'h0}, 33);
        check("R7 unprotect op", last_op, 8'h39);
        eng_done = 1; @(negedge clk); eng_done = 0; m_wel = 0;

        // R8 short engine commands abort
        s0 = starts;
        for (int k = 0; k < 4; k++) begin
            wren();
            case (k)
                0: cmd({8'h20, 32'h0}, 8);
                1: cmd({8'h20, 32'h0}, 16);
                2: cmd({8'h36, 32'h0}, 31);
                default: cmd({8'h02, 32'h0}, 39);
            endcase
            m_wel = 0;
            rd1(b);
            check($sformatf("R8 short k=%0d", k), b, st(0));
        end
        check("R8 no start", starts, s0);

        // R11 busy gate with engine outstanding
        wren(); cmd({8'h60, 32'h0}, 8); s0 = starts;
        cmd({8'h04, 32'h0}, 8);
        cmd({8'h60, 32'h0}, 8);
        rd1(b); check("R11 wrdi ignored", b, st(1));
        check("R11 no second start", starts, s0);

        // R3 / R10 stream across completion
        fork
            rd(4, g, a, c);
            begin repeat (74) @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0; end
        join
        check("R3 stream byte0", g[31:24], st(1));
        m_wel = 0;
        check("R3 stream byte3", g[7:0], st(0));
        check("R3 oe during stream", c, 0);

        // R11 busy stub after status write
        busy_len = 16'd120;
        wren(); cmd({8'h01, 8'h00, 24'h0}, 16); m_wel = 0; m_allp = 0;
        cmd({8'h06, 32'h0}, 8);
        rd1(b); check("R11 wren ignored in stub", b, st(1));
        repeat (150) @(negedge clk);
        rd1(b); check("R10 stub expires", b, st(0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule